// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block decodes the memory-mapped configuration window of a PCIe host bridge. An 8-byte control register is loaded through a byte-enabled configuration write port, addressed in 32-bit words. The register carries three things: an enable flag, a two-bit size select and the window base. From these the block derives the effective enable, the window size, an address mask and the aligned base address. It shows all four on plain status pins.

Physical addresses arrive on a valid/ready request stream. Each accepted address yields one response on a valid/ready result stream in the following cycle. The response says whether the address falls inside the window and, on a hit, gives the byte offset within the window. A request is accepted on a rising clock edge when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result slot is empty or the result is being taken in the same cycle. A result is consumed on an edge where `resp_valid` and `resp_ready` are both high. While a result is held back it stays unchanged.

A size select value of 3 is reserved. While the register holds it, the window is forced off. It also sets a sticky error flag, which only reset clears.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register holds RST_VAL (default base 0xB000_0000, enable 0, size select 0). `win_enable` is 0, `win_len` is 0, `win_base` is 0xB000_0000, `len_err` is 0 and `resp_valid` is 0.
- R2: A write with `cfg_wr_en` high updates register byte k only if two conditions hold. First, `cfg_wr_dw` must equal CFG_REG_DW + k/4. Second, `cfg_wr_be[k%4]` must be set. The byte then takes `cfg_wr_data[8*(k%4)+7 : 8*(k%4)]`. Every other byte keeps its value, and writes to any other word change nothing.
- R3: Register bit 0 is the enable. While it is 0, every request misses.
- R4: Register bits [2:1] = 0 select a 256 MB window. An address hits when address[35:28] equals register bits [35:28]; register bits [27:26] are ignored. The offset is address[27:0].
- R5: Size select 1 selects a 128 MB window. The compare uses bits [35:27] and the offset is address[26:0].
- R6: Size select 2 selects a 64 MB window. The compare uses bits [35:26] and the offset is address[25:0].
- R7: While size select is 3, `win_enable` is 0 and every request misses. `len_err` rises with the write that stores size select 3. It stays high after a legal size is written, until reset.
- R8: A miss returns offset 0. `win_base` is the register's bits [35:0] with everything below the window size cleared.
- R9: Each accepted request produces exactly one response, in order, one cycle after acceptance. `req_ready` equals `!resp_valid || resp_ready`. While `resp_valid` is high and `resp_ready` is low, the hit and offset outputs hold.
- R10: A request is decoded with the register value in force before the edge that accepts it. A register write on that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | CFG_DW_W (10) | Configuration word index of the write |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W (36) | Physical address to decode |
| resp_valid | output | 1 | Result valid |
| resp_ready | input | 1 | Result consumer ready |
| resp_hit | output | 1 | Address lies in the window |
| resp_offset | output | 28 | Offset inside the window, 0 on a miss |
| win_enable | output | 1 | Effective window enable |
| win_len | output | 2 | Size select held in the register |
| win_base | output | ADDR_W (36) | Aligned window base |
| len_err | output | 1 | Sticky reserved-size flag |

## Verification
Each window size is tried with three kinds of address. One lies just inside the base. One lies at the top of the window. The third lies just past the window or in the region only a smaller window would exclude. Together these separate the three compare widths and the three offset widths.

The 256 MB case uses a base whose low bits 27:26 are set, which proves those bits are ignored. Partial byte-enable writes, an upper-word write and a write to a foreign word show which bytes change. The reserved size is written and then overwritten with a legal size, which tells a sticky flag from a live one. Bursts with `resp_ready` held low test back-pressure, and a write on the same edge as a request tests the ordering in R10.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
package cfgwin_pkg;
  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } win_len_e;

  localparam int unsigned EN_POS    = 0;
  localparam int unsigned LEN_LO    = 1;
  localparam int unsigned SHIFT_MAX = 28;
  localparam int unsigned SHIFT_MIN = 26;

  function automatic int unsigned win_shift(win_len_e l);
    case (l)
      LEN_128M: return SHIFT_MAX - 1;
      LEN_64M:  return SHIFT_MIN;
      default:  return SHIFT_MAX;
    endcase
  endfunction
endpackage

// File: rtl/cfgwin_regfile.sv
`timescale 1ns/1ps
module cfgwin_regfile
  import cfgwin_pkg::*;
#(
  parameter int unsigned DW_W    = 10,
  parameter int unsigned REG_DW  = 24,
  parameter int unsigned VIEW_W  = 36,
  parameter logic [63:0] RST_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW_W-1:0]   wr_dw,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic [VIEW_W-1:0] reg_view,
  output logic              len_err
);
  localparam int unsigned NBYTES = 8;
  localparam int unsigned LANES  = 4;

  logic [NBYTES*8-1:0] reg_q;
  logic [NBYTES*8-1:0] reg_d;
  logic                err_q;
  logic                err_d;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int unsigned WORD = b / LANES;
    localparam int unsigned LANE = b % LANES;
    logic sel;
    assign sel = wr_en && (wr_dw == DW_W'(REG_DW + WORD)) && wr_be[LANE];
    assign reg_d[b*8 +: 8] = sel ? wr_data[LANE*8 +: 8] : reg_q[b*8 +: 8];
  end

  assign err_d = err_q || (win_len_e'(reg_d[LEN_LO +: 2]) == LEN_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= RST_VAL;
      err_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      err_q <= err_d;
    end
  end

  assign reg_view = reg_q[VIEW_W-1:0];
  assign len_err  = err_q;

  // R2: without a write strobe the register does not move
  a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));
  // R7: the error flag never falls outside reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7: holding the reserved size implies the flag is up
  a_r7_err_when_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[LEN_LO +: 2] == 2'b11) |-> err_q);
endmodule

// File: rtl/cfgwin_map.sv
`timescale 1ns/1ps
module cfgwin_map
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W = 36
) (
  input  logic [ADDR_W-1:0] reg_view,
  output logic              win_en,
  output win_len_e          win_len,
  output logic [ADDR_W-1:0] win_mask,
  output logic [ADDR_W-1:0] win_base
);
  always_comb begin
    win_len  = win_len_e'(reg_view[LEN_LO +: 2]);
    win_en   = reg_view[EN_POS] && (win_len != LEN_RSVD);
    win_mask = ~((ADDR_W'(1) << win_shift(win_len)) - ADDR_W'(1));
    win_base = reg_view & win_mask;
  end
endmodule

// File: rtl/cfgwin_match.sv
`timescale 1ns/1ps
module cfgwin_match #(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned OFF_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic [ADDR_W-1:0] win_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic [OFF_W-1:0]  resp_offset
);
  logic             accept;
  logic             hit_c;
  logic [OFF_W-1:0] off_c;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign hit_c     = win_en && ((req_addr & win_mask) == win_base);
  assign off_c     = hit_c ? (req_addr[OFF_W-1:0] & ~win_mask[OFF_W-1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_offset <= '0;
    end else if (accept) begin
      resp_valid  <= 1'b1;
      resp_hit    <= hit_c;
      resp_offset <= off_c;
    end else if (resp_ready) begin
      resp_valid  <= 1'b0;
    end
  end

  // R9: a stalled result holds its payload
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit) && $stable(resp_offset)));
  // R9: a stalled result blocks new requests
  a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready);
  // R8: a miss carries a zero offset
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_offset == '0));
endmodule

// File: rtl/cfgwin_decoder.sv
`timescale 1ns/1ps
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W     = 36,
  parameter int unsigned CFG_DW_W   = 10,
  parameter int unsigned CFG_REG_DW = 24,
  parameter logic [63:0] RST_VAL    = 64'h0000_0000_B000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [CFG_DW_W-1:0]  cfg_wr_dw,
  input  logic [3:0]           cfg_wr_be,
  input  logic [31:0]          cfg_wr_data,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic                 resp_hit,
  output logic [SHIFT_MAX-1:0] resp_offset,
  output logic                 win_enable,
  output logic [1:0]           win_len,
  output logic [ADDR_W-1:0]    win_base,
  output logic                 len_err
);
  localparam int unsigned OFF_W = SHIFT_MAX;

  logic [ADDR_W-1:0] reg_view;
  logic [ADDR_W-1:0] mask;
  win_len_e          len_e;

  cfgwin_regfile #(
    .DW_W(CFG_DW_W), .REG_DW(CFG_REG_DW), .VIEW_W(ADDR_W), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw),
    .wr_be(cfg_wr_be), .wr_data(cfg_wr_data), .reg_view(reg_view), .len_err(len_err)
  );

  cfgwin_map #(.ADDR_W(ADDR_W)) u_map (
    .reg_view(reg_view), .win_en(win_enable), .win_len(len_e),
    .win_mask(mask), .win_base(win_base)
  );

  cfgwin_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .clk(clk), .rst_n(rst_n), .win_en(win_enable), .win_mask(mask), .win_base(win_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
    .resp_offset(resp_offset)
  );

  assign win_len = len_e;

  // R7: the reserved size never leaves the window on
  a_r7_rsvd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == 2'b11) |-> !win_enable);
endmodule

// File: tb/test_cfgwin_decoder.sv
`timescale 1ns/1ps
module test_cfgwin_decoder;
  localparam int unsigned REG_DW = 24;
  localparam logic [63:0] RST_VAL = 64'h0000_0000_B000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [9:0]  cfg_wr_dw = '0;
  logic [3:0]  cfg_wr_be = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic        resp_hit;
  logic [27:0] resp_offset;
  logic        win_enable;
  logic [1:0]  win_len;
  logic [35:0] win_base;
  logic        len_err;

  always #4 clk = ~clk;

  cfgwin_decoder i_cfgwin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
    .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_hit(resp_hit), .resp_offset(resp_offset),
    .win_enable(win_enable), .win_len(win_len), .win_base(win_base), .len_err(len_err)
  );

  typedef struct {
    logic        hit;
    logic [27:0] off;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] mreg = RST_VAL;
  int          cyc = 0;
  int          stall_lo = 0;
  int          stall_hi = 0;
  logic        force_ready = 1'b0;
  logic        mon_on = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic item_t model(logic [63:0] r, logic [35:0] a, string tag);
    item_t it;
    int    sh;
    logic  en;
    en = r[0];
    case (r[2:1])
      2'd0: sh = 28;
      2'd1: sh = 27;
      2'd2: sh = 26;
      default: begin sh = 28; en = 1'b0; end
    endcase
    it.tag = tag;
    it.hit = en && ((a >> sh) == (r[35:0] >> sh));
    it.off = it.hit ? 28'(a & ((36'd1 << sh) - 36'd1)) : 28'd0;
    return it;
  endfunction

  task automatic mirror_write(logic [9:0] dw, logic [3:0] be, logic [31:0] d);
    for (int k = 0; k < 2; k++)
      if (dw == 10'(REG_DW + k))
        for (int l = 0; l < 4; l++)
          if (be[l]) mreg[(k*4+l)*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic wr(logic [9:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_dw = dw; cfg_wr_be = be; cfg_wr_data = d;
    mirror_write(dw, be, d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic send(logic [35:0] a, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    sb.push_back(model(mreg, a, tag));
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: scoreboard pop/compare and back-pressure generation
  initial begin
    logic        held;
    logic        hh;
    logic [27:0] ho;
    item_t       it;
    held = 1'b0; hh = 1'b0; ho = '0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (held) begin
        chk("R9 stalled valid", resp_valid, 1);
        chk("R9 stalled hit", resp_hit, hh);
        chk("R9 stalled offset", resp_offset, ho);
      end
      cyc++;
      resp_ready = force_ready || ((cyc % 5 != 2) && !(cyc >= stall_lo && cyc < stall_hi));
      held = resp_valid && !resp_ready;
      hh = resp_hit; ho = resp_offset;
      if (resp_valid && resp_ready) begin
        if (sb.size() == 0) chk("R9 unexpected response", 1, 0);
        else begin
          it = sb.pop_front();
          chk({it.tag, " hit"}, resp_hit, it.hit);
          chk({it.tag, " offset"}, resp_offset, it.off);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 win_enable", win_enable, 0);
    chk("R1 win_len", win_len, 0);
    chk("R1 win_base", win_base, 36'hB000_0000);
    chk("R1 len_err", len_err, 0);
    chk("R1 resp_valid", resp_valid, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R3 disabled window
    send(36'hB000_0010, "R3 disabled base");
    send(36'h0_0000_1234, "R3 disabled low");

    // R4 256 MB, base bits 27:26 set but ignored
    wr(10'(REG_DW), 4'hF, 32'hBC00_0001);
    chk("R4 win_base", win_base, 36'hB000_0000);
    chk("R4 win_enable", win_enable, 1);
    send(36'hB000_0010, "R4 inside");
    send(36'hBFFF_FFFF, "R4 top");
    send(36'hC000_0000, "R4 past end");
    send(36'hA000_0000, "R4 below");

    // R5 128 MB via byte-0-only write (R2)
    wr(10'(REG_DW), 4'h1, 32'hFFFF_FF03);
    chk("R2 partial write base", win_base, 36'hB800_0000);
    chk("R5 win_len", win_len, 1);
    send(36'hB800_0100, "R5 inside");
    send(36'hB000_0000, "R5 lower half");
    send(36'hBFFF_FFFF, "R5 top");

    // R6 64 MB
    wr(10'(REG_DW), 4'h1, 32'h0000_0005);
    chk("R6 win_base", win_base, 36'hBC00_0000);
    send(36'hBC00_0004, "R6 inside");
    send(36'hB800_0000, "R6 below");
    send(36'hBFFF_FFFF, "R6 top");

    // R2 upper word, then foreign word
    wr(10'(REG_DW + 1), 4'h1, 32'h0000_0001);
    chk("R2 upper word base", win_base, 36'h1_BC00_0000);
    send(36'h0_BC00_0004, "R2 old base misses");
    send(36'h1_BC00_0008, "R2 new base hits");
    wr(10'(REG_DW + 2), 4'hF, 32'h0000_0000);
    chk("R2 foreign word base", win_base, 36'h1_BC00_0000);
    chk("R2 foreign word enable", win_enable, 1);

    // R3 enable cleared
    wr(10'(REG_DW), 4'h1, 32'h0000_0004);
    chk("R3 win_enable", win_enable, 0);
    send(36'h1_BC00_0008, "R3 cleared enable");

    // R7 reserved size
    wr(10'(REG_DW), 4'h1, 32'h0000_0007);
    chk("R7 len_err set", len_err, 1);
    chk("R7 window off", win_enable, 0);
    send(36'h1_BC00_0008, "R7 reserved miss");
    wr(10'(REG_DW), 4'h1, 32'h0000_0005);
    chk("R7 len_err sticky", len_err, 1);
    chk("R7 legal enable back", win_enable, 1);
    send(36'h1_BFFF_FFF0, "R7 legal again");
    send(36'h1_C000_0000, "R8 miss past end");

    // R9 back-pressure burst
    drain();
    stall_lo = cyc + 2;
    stall_hi = cyc + 9;
    for (int i = 0; i < 8; i++)
      send(36'h1_BC00_0000 + 36'(i * 36'h40_0040), "R9 burst");
    drain();

    // R10 write on the accepting edge
    force_ready = 1'b1;
    drain();
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_dw = 10'(REG_DW); cfg_wr_be = 4'h1; cfg_wr_data = 32'h0000_0004;
    req_valid = 1'b1; req_addr = 36'h1_BC00_0010;
    sb.push_back(model(mreg, 36'h1_BC00_0010, "R10 same edge uses old"));
    mirror_write(10'(REG_DW), 4'h1, 32'h0000_0004);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    send(36'h1_BC00_0010, "R10 later uses new");
    drain();
    force_ready = 1'b0;

    chk("R9 scoreboard empty", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule